// File: doc/BRIEF.md
# GPIO Port Controller with Edge and Level Interrupt Detection

This block controls a port of general-purpose pins through a small memory-mapped register bus. Software drives the pins from an output data register. It can write that register as a whole, or change single bits without a read-modify-write by using a set alias or a clear alias. Pin levels pass through a two-stage synchronizer and can be read back in one access. Each pin has its own configuration word. The word selects push-pull or open-drain drive, enables the output driver, picks a 3-bit trigger code and holds an interrupt-enable field.

Detected events set bits in a pending register. Software clears pending bits by writing ones to an acknowledge alias. A single interrupt line is raised when any pending pin has a valid trigger code and its first-processor enable bit set. The trigger code acts as the per-pin detector mode:

- `TRG_OFF` (0): no detection.
- `TRG_RISE` (1): rising edge.
- `TRG_FALL` (2): falling edge.
- `TRG_ANY` (3): either edge.
- `TRG_LOW` (4): low level.
- `TRG_HIGH` (5): high level.
- `TRG_RSV6` and `TRG_RSV7` (6, 7): treated as off.

Bus accesses are decoded into one of these register selections: `SEL_OUT`, `SEL_SET`, `SEL_CLR`, `SEL_IN`, `SEL_PEND`, `SEL_ACK`, `SEL_CFG` and `SEL_NONE`. Each selection is taken for a single cycle while the bus is selected.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the output data register, every configuration word, the pending register, `pad_oe`, `pad_out` and `irq` are all zero.
- R2: A write to the output data register (address 0x00) replaces it. A read returns the new value, and `pad_out` of a push-pull pin follows it on the next cycle.
- R3: Writing the set alias (address 0x04) sets each output bit written as 1 and leaves all other bits unchanged.
- R4: Writing the clear alias (address 0x08) clears each output bit written as 1 and leaves all other bits unchanged.
- R5: The input register (address 0x0C) returns all pin levels. A pin change made before clock edge k is visible after edge k+1 and not after edge k.
- R6: With trigger code 1, 2 or 3 (configuration bits 6:4), a rising, falling or any edge respectively sets the pin's pending bit (register 0x10, bit = pin).
- R7: With trigger code 4 or 5, a low or high level respectively sets the pending bit. The bit is set again on every cycle the level holds, so an acknowledge while the level persists leaves it set.
- R8: Writing the acknowledge alias (address 0x14) clears exactly the pending bits written as 1.
- R9: Trigger codes 0, 6 and 7 never set a pending bit.
- R10: `irq` is high exactly when some pin has its pending bit set, a trigger code from 1 to 5, and configuration bit 10 set (bit 2 of the enable field, bits 12:8).
- R11: Configuration bit 0 selects open-drain and bit 1 enables the driver. An open-drain pin has `pad_out` 0 and drives (`pad_oe` 1) only when its output bit is 0. A push-pull pin has `pad_oe` equal to bit 1 and `pad_out` equal to its output bit.
- R12: Configuration words live at 0x80 + 4·pin and read back only bits 12:8, 6:4, 1 and 0. The write-only aliases read as 0. Writes to the input and pending registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational during a read |
| pin_in | input | NPINS (32) | Pin levels from the pads |
| pad_out | output | NPINS (32) | Pad output value |
| pad_oe | output | NPINS (32) | Pad output enable |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is combinational, so the bench samples `bus_rdata` one time unit after presenting a read at the falling edge. A register write takes effect at the next rising edge, and `pad_out` and `pad_oe` are checked at the falling edge after it. A pin change reaches the input register two rising edges later and the pending register and `irq` three edges later. The bench therefore waits four cycles after each pin stimulus before it reads. The R5 check deliberately samples after one edge to confirm the old value is still present. The sweep covers all eight trigger codes across all pins, using rise, hold and fall phases whose pending values are computed from the code.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [2:0] {
        TRG_OFF  = 3'd0,
        TRG_RISE = 3'd1,
        TRG_FALL = 3'd2,
        TRG_ANY  = 3'd3,
        TRG_LOW  = 3'd4,
        TRG_HIGH = 3'd5,
        TRG_RSV6 = 3'd6,
        TRG_RSV7 = 3'd7
    } trig_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_SET,
        SEL_CLR,
        SEL_IN,
        SEL_PEND,
        SEL_ACK,
        SEL_CFG
    } sel_e;

    typedef struct packed {
        logic [4:0] en;     // interrupt enable field, bit 2 = first processor
        trig_e      trig;   // trigger code
        logic       drv;    // output driver enable
        logic       od;     // open-drain select
    } pin_cfg_t;

    localparam int EN_CPU0_BIT = 2;

    function automatic logic trig_valid(input trig_e t);
        return (t != TRG_OFF) && (t != TRG_RSV6) && (t != TRG_RSV7);
    endfunction

    function automatic logic [31:0] cfg_pack(input pin_cfg_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.od;
        w[1]     = c.drv;
        w[6:4]   = c.trig;
        w[12:8]  = c.en;
        return w;
    endfunction

    function automatic pin_cfg_t cfg_unpack(input logic [31:0] w);
        pin_cfg_t c;
        c.od   = w[0];
        c.drv  = w[1];
        c.trig = trig_e'(w[6:4]);
        c.en   = w[12:8];
        return c;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] level_prev
);

    logic [NPINS-1:0] stage1_q;
    logic [NPINS-1:0] stage2_q;
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= pin_in;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign level      = stage2_q;
    assign level_prev = prev_q;

    // R5
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_prev == $past(level));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic [NPINS-1:0]      level,
    input  logic [NPINS-1:0]      pend,
    output logic [NPINS-1:0]      out_q,
    output pin_cfg_t [NPINS-1:0]  cfg_q,
    output logic [NPINS-1:0]      ack_mask
);

    localparam int IDX_W = AW - 3;

    sel_e             sel;
    logic [IDX_W-1:0] cfg_idx;
    logic             wr_en;
    logic [NPINS-1:0] wmask;

    assign cfg_idx = bus_addr[AW-2:2];
    assign wmask   = bus_wdata[NPINS-1:0];
    assign wr_en   = bus_sel && bus_wr;

    always_comb begin
        sel = SEL_NONE;
        if (bus_sel && (bus_addr[1:0] == 2'b00)) begin
            if (bus_addr[AW-1]) begin
                if (int'(cfg_idx) < NPINS) sel = SEL_CFG;
            end else begin
                unique case (int'(cfg_idx))
                    0:       sel = SEL_OUT;
                    1:       sel = SEL_SET;
                    2:       sel = SEL_CLR;
                    3:       sel = SEL_IN;
                    4:       sel = SEL_PEND;
                    5:       sel = SEL_ACK;
                    default: sel = SEL_NONE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_OUT: out_q <= wmask;
                SEL_SET: out_q <= out_q | wmask;
                SEL_CLR: out_q <= out_q & ~wmask;
                SEL_NONE, SEL_IN, SEL_PEND, SEL_ACK, SEL_CFG: out_q <= out_q;
            endcase
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (wr_en && (sel == SEL_CFG) && (int'(cfg_idx) == g)) begin
                cfg_q[g] <= cfg_unpack(bus_wdata[31:0]);
            end
        end
    end

    assign ack_mask = (wr_en && (sel == SEL_ACK)) ? wmask : '0;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                SEL_OUT:  bus_rdata[NPINS-1:0] = out_q;
                SEL_IN:   bus_rdata[NPINS-1:0] = level;
                SEL_PEND: bus_rdata[NPINS-1:0] = pend;
                SEL_CFG:  bus_rdata[31:0]      = cfg_pack(cfg_q[cfg_idx]);
                SEL_NONE, SEL_SET, SEL_CLR, SEL_ACK: bus_rdata = '0;
            endcase
        end
    end

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SET) |=> ((out_q & $past(wmask)) == $past(wmask)));

    // R4
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CLR) |=> ((out_q & $past(wmask)) == '0));

    // R12
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel == SEL_OUT || sel == SEL_SET || sel == SEL_CLR)) |=> $stable(out_q));

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      level,
    input  logic [NPINS-1:0]      level_prev,
    input  pin_cfg_t [NPINS-1:0]  cfg_q,
    input  logic [NPINS-1:0]      ack_mask,
    output logic [NPINS-1:0]      pend_q,
    output logic                  irq
);

    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] armed;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise_w;
        logic fall_w;

        assign rise_w = level[g] & ~level_prev[g];
        assign fall_w = ~level[g] & level_prev[g];

        always_comb begin
            hit[g] = 1'b0;
            unique case (cfg_q[g].trig)
                TRG_RISE: hit[g] = rise_w;
                TRG_FALL: hit[g] = fall_w;
                TRG_ANY:  hit[g] = rise_w | fall_w;
                TRG_LOW:  hit[g] = ~level[g];
                TRG_HIGH: hit[g] = level[g];
                TRG_OFF, TRG_RSV6, TRG_RSV7: hit[g] = 1'b0;
            endcase
        end

        // set has priority over acknowledge, so a held level stays pending
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= (pend_q[g] & ~ack_mask[g]) | hit[g];
        end

        assign armed[g] = cfg_q[g].en[EN_CPU0_BIT] & trig_valid(cfg_q[g].trig);

        // R9
        off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_valid(cfg_q[g].trig) |=> !$rose(pend_q[g]));

        // R8
        ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_mask[g] && !hit[g]) |=> !pend_q[g]);

        // R7
        level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_q[g].trig == TRG_HIGH && level[g]) ||
             (cfg_q[g].trig == TRG_LOW && !level[g])) |=> pend_q[g]);

        // R6
        rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[g].trig == TRG_RISE && level[g] && !level_prev[g]) |=> pend_q[g]);
    end

    assign irq = |(pend_q & armed);

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_q != '0));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             irq
);

    logic [NPINS-1:0]     level;
    logic [NPINS-1:0]     level_prev;
    logic [NPINS-1:0]     out_q;
    logic [NPINS-1:0]     pend_q;
    logic [NPINS-1:0]     ack_mask;
    pin_cfg_t [NPINS-1:0] cfg_q;

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .level      (level),
        .level_prev (level_prev)
    );

    gpio_regfile #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level     (level),
        .pend      (pend_q),
        .out_q     (out_q),
        .cfg_q     (cfg_q),
        .ack_mask  (ack_mask)
    );

    gpio_evt_detect #(.NPINS(NPINS)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .level_prev (level_prev),
        .cfg_q      (cfg_q),
        .ack_mask   (ack_mask),
        .pend_q     (pend_q),
        .irq        (irq)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pad
        always_comb begin
            if (cfg_q[g].od) begin
                pad_out[g] = 1'b0;
                pad_oe[g]  = cfg_q[g].drv & ~out_q[g];
            end else begin
                pad_out[g] = out_q[g];
                pad_oe[g]  = cfg_q[g].drv;
            end
        end

        // R11
        od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[g].od |-> (!pad_out[g] && !(pad_oe[g] && out_q[g])));
    end

endmodule

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;

    localparam int NPINS = 32;
    localparam int AW    = 8;
    localparam int DW    = 32;

    localparam logic [7:0] A_OUT  = 8'h00;
    localparam logic [7:0] A_SET  = 8'h04;
    localparam logic [7:0] A_CLR  = 8'h08;
    localparam logic [7:0] A_IN   = 8'h0C;
    localparam logic [7:0] A_PEND = 8'h10;
    localparam logic [7:0] A_ACK  = 8'h14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [NPINS-1:0] pin_in = '0;
    logic [NPINS-1:0] pad_out;
    logic [NPINS-1:0] pad_oe;
    logic            irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpio_port_ctrl #(.NPINS(NPINS), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_all(input logic [31:0] w);
        for (int p = 0; p < NPINS; p++) wr(8'h80 + 8'(p * 4), w);
    endtask

    function automatic logic [31:0] cfg_word(input int code, input bit en0, input bit drv, input bit od);
        return (32'(en0) << 10) | (32'(code) << 4) | (32'(drv) << 1) | 32'(od);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] model;
        logic [31:0] pat;
        logic [31:0] ep;
        logic [31:0] vals [4];
        vals[0] = 32'hA5A5_0F0F; vals[1] = 32'h0000_0001;
        vals[2] = 32'h8000_0000; vals[3] = 32'hFFFF_FFFF;

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        rd(A_OUT, d);  chk("R1 out", d, 0);
        rd(A_PEND, d); chk("R1 pend", d, 0);
        rd(8'h80, d);  chk("R1 cfg0", d, 0);
        rd(8'hFC, d);  chk("R1 cfg31", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_out", pad_out, 0);

        // R2 direct write, push-pull pads follow
        cfg_all(cfg_word(0, 0, 1, 0));
        for (int i = 0; i < 4; i++) begin
            wr(A_OUT, vals[i]);
            rd(A_OUT, d); chk("R2 readback", d, vals[i]);
            chk("R2 pad_out", pad_out, vals[i]);
            chk("R11 pp oe", pad_oe, 32'hFFFF_FFFF);
        end

        // R3 / R4 set and clear alias sweep
        model = 32'h1234_5678;
        wr(A_OUT, model);
        for (int i = 0; i < 16; i++) begin
            pat = 32'h0F1E_2D3C * (i + 1) ^ (32'h1 << i);
            if (i[0]) begin
                wr(A_SET, pat); model = model | pat;
                rd(A_OUT, d); chk("R3 set", d, model);
            end else begin
                wr(A_CLR, pat); model = model & ~pat;
                rd(A_OUT, d); chk("R4 clr", d, model);
            end
        end

        // R5 input synchronizer latency
        @(negedge clk); pin_in = 32'hC3C3_5A5A;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_IN; #1 d = bus_rdata; bus_sel = 1'b0;
        chk("R5 one edge old", d, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_IN; #1 d = bus_rdata; bus_sel = 1'b0;
        chk("R5 two edges new", d, 32'hC3C3_5A5A);
        pin_in = '0;
        wait_cyc(4);

        // R6 R7 R9 R10 sweep over all trigger codes
        pat = 32'h0F0F_A5C3;
        for (int c = 0; c < 8; c++) begin
            pin_in = '0;
            cfg_all(cfg_word(c, 1, 0, 0));
            wait_cyc(4);
            wr(A_ACK, 32'hFFFF_FFFF);
            ep = (c == 4) ? 32'hFFFF_FFFF : 32'h0;
            rd(A_PEND, d); chk($sformatf("R7 R9 idle code%0d", c), d, ep);
            chk("R10 irq idle", {31'b0, irq}, {31'b0, ep != 0});

            @(negedge clk); pin_in = pat;
            wait_cyc(4);
            ep = (c == 1 || c == 3 || c == 5) ? pat : (c == 4) ? 32'hFFFF_FFFF : 32'h0;
            rd(A_PEND, d); chk($sformatf("R6 R7 R9 rise code%0d", c), d, ep);
            chk("R10 irq rise", {31'b0, irq}, {31'b0, ep != 0});

            wr(A_ACK, 32'hFFFF_FFFF);
            wait_cyc(1);
            ep = (c == 5) ? pat : (c == 4) ? ~pat : 32'h0;
            rd(A_PEND, d); chk($sformatf("R7 R8 hold code%0d", c), d, ep);

            @(negedge clk); pin_in = '0;
            wait_cyc(4);
            ep = (c == 2 || c == 3 || c == 5) ? pat : (c == 4) ? 32'hFFFF_FFFF : 32'h0;
            rd(A_PEND, d); chk($sformatf("R6 R7 R9 fall code%0d", c), d, ep);
            chk("R10 irq fall", {31'b0, irq}, {31'b0, ep != 0});
        end

        // R8 exact clear, R10 enable gating
        cfg_all(cfg_word(1, 0, 0, 0));
        wr(A_ACK, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = pat;
        wait_cyc(4);
        rd(A_PEND, d); chk("R6 rise no enable", d, pat);
        chk("R10 irq disabled", {31'b0, irq}, 0);
        wr(A_ACK, 32'h00FF_00F0);
        rd(A_PEND, d); chk("R8 partial ack", d, pat & ~32'h00FF_00F0);
        wr(8'h80, cfg_word(1, 1, 0, 0));
        chk("R10 irq pin0 enabled", {31'b0, irq}, {31'b0, pat[0] & ~1'b0});
        wr(A_ACK, 32'hFFFF_FFFF);
        pin_in = '0;
        wait_cyc(4);

        // R11 open-drain and driver enable
        wr(A_OUT, 32'h0000_0008);
        wr(8'h8C, cfg_word(0, 0, 1, 1));
        wr(8'h90, cfg_word(0, 0, 1, 0));
        wr(8'h94, cfg_word(0, 0, 0, 0));
        chk("R11 od high released", {30'b0, pad_oe[3], pad_out[3]}, 32'h0);
        chk("R11 pp low driven", {30'b0, pad_oe[4], pad_out[4]}, 32'h2);
        wr(A_OUT, 32'h0000_0030);
        chk("R11 od low driven", {30'b0, pad_oe[3], pad_out[3]}, 32'h2);
        chk("R11 pp high driven", {30'b0, pad_oe[4], pad_out[4]}, 32'h3);
        chk("R11 drv off", {30'b0, pad_oe[5], pad_out[5]}, 32'h1);

        // R12 field readback, alias reads, ignored writes
        wr(8'h94, 32'hFFFF_FFFF);
        rd(8'h94, d); chk("R12 cfg fields", d, 32'h0000_1F73);
        rd(A_SET, d); chk("R12 set reads 0", d, 0);
        rd(A_ACK, d); chk("R12 ack reads 0", d, 0);
        wr(8'h94, 0);
        cfg_all(cfg_word(5, 0, 0, 0));
        @(negedge clk); pin_in = 32'h0000_0101;
        wait_cyc(4);
        wr(A_PEND, 32'h0);
        wr(A_IN, 32'hFFFF_FFFF);
        rd(A_PEND, d); chk("R12 pend write ignored", d, 32'h0000_0101);
        rd(A_IN, d);   chk("R12 in write ignored", d, 32'h0000_0101);
        rd(A_OUT, d);  chk("R12 out untouched", d, 32'h0000_0030);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule